// File: doc/BRIEF.md
# Activate-Write-Autoprecharge Command Sequencer

This block sits on the controller side of a DDR SDRAM interface and turns one request into a complete single-bank write access. A request names a bank, a row, a column and a device data-width mode. The sequencer issues an ACTIVE carrying the bank and row. After the activate-to-write delay it issues a WRITE carrying the column, with address bit 10 set so that the device closes the row by itself once the burst is written. Every other cycle carries NOP, with the bank and address buses parked at zero.

All timing values are parameters counted in clock cycles. No explicit PRECHARGE is ever sent, but the sequencer still works out when the device's internal precharge begins. That point is the later of two events: the end of write recovery after the last data beat, and the end of the minimum row-active time. The sequencer then holds off the next request until the precharge interval has also elapsed. A ready/valid handshake takes requests. A one-cycle done pulse marks the first cycle in which a new request can be accepted. Its ACTIVE then lands exactly on the earliest legal cycle.

With the default parameters, WRITE follows ACTIVE after 3 cycles. The write data starts 1 cycle after WRITE and lasts 2 cycles for a burst of 4. Write recovery takes 2 cycles, the minimum row-active time is 6 cycles and precharge takes 3 cycles. The precharge point is therefore 8 cycles after ACTIVE, and the next ACTIVE may come 11 cycles after the previous one.

Top module: `ddr_wap_sequencer`

## Requirements
- R1: After synchronous reset the command pins read NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `ba` and `addr` are zero, `req_ready` is 1 and `done` is 0.
- R2: When `req_valid` and `req_ready` are both high at a rising edge, the next cycle (cycle 0) carries ACTIVE (4'b0011) with `ba` = requested bank and `addr` = requested row.
- R3: Exactly T_RCD cycles after ACTIVE (cycle 3 by default) the pins carry WRITE (4'b0100) with `ba` = the same bank and `addr[10]` = 1.
- R4: In mode 2'b00 (x4), the WRITE address carries col[9:0] on addr[9:0] and col[10] on addr[11]; every other bit except addr[10] is 0.
- R5: In mode 2'b01 (x8), the WRITE address carries col[9:0] on addr[9:0]; every other bit except addr[10] is 0.
- R6: In mode 2'b10 (x16) and in the reserved mode 2'b11, the WRITE address carries col[8:0] on addr[8:0]; every other bit except addr[10] is 0.
- R7: Every cycle that carries neither ACTIVE nor WRITE carries NOP, with `addr` and `ba` zero.
- R8: `req_ready` is low from cycle 0 through cycle DONE_AT-2. In cycle DONE_AT-1 it is high and `done` is high for that one cycle only. Here DONE_AT = max(T_RCD+WL+BL/2+T_WR, T_RAS) + T_RP, which is 11 by default.
- R9: The precharge point is the later of the write-recovery end and T_RAS. With T_RAS = 10 and the other values at default, `done` rises in cycle 12.
- R10: A request presented while `req_ready` is low is ignored: no extra ACTIVE appears, and the WRITE keeps the bank and column of the accepted request.
- R11: A request accepted in the done cycle produces its ACTIVE exactly DONE_AT cycles after the previous ACTIVE.
- R12: Reset asserted during a sequence aborts it. The outputs return to the R1 state, and a later request runs a full normal sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ADDR_W | Row address |
| req_col | input | 11 | Column address (bits used depend on mode) |
| req_mode | input | 2 | Device width: 00 x4, 01 x8, 10/11 x16 |
| done | output | 1 | One-cycle pulse: bank may be activated again |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Multiplexed row/column address |

## Verification
The main sequence runs on a set of requests that differ in bank, row, column and width mode. Each column value carries set bits in positions that only some modes pass through (bit 9, bit 10), so a wrong mode mapping or a misplaced auto-precharge bit shows up as a different WRITE address. One request has an intruding second request held high while the sequencer is busy, which separates a design that ignores it from one that restarts or relatches. Back-to-back requests, a mid-sequence reset and a second instance whose row-active time dominates test the spacing, abort and precharge-point rules.

// File: rtl/ddr_wap_pkg.sv
package ddr_wap_pkg;

  localparam int COL_W = 11;

  localparam logic [1:0] MODE_X4  = 2'b00;
  localparam logic [1:0] MODE_X8  = 2'b01;
  localparam logic [1:0] MODE_X16 = 2'b10;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_NOP = 4'b0111
  } cmd_e;

  // Cycle (relative to ACTIVE) at which the device starts its own precharge
  function automatic int pre_point(int rcd, int wl, int bl, int twr, int tras);
    int rec_end;
    rec_end = rcd + wl + bl / 2 + twr;
    return (rec_end > tras) ? rec_end : tras;
  endfunction

endpackage

// File: rtl/ddr_wap_timer.sv
module ddr_wap_timer #(
  parameter int T_RCD   = 3,
  parameter int DONE_AT = 11,
  parameter int CNT_W   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fire_wr,
  output logic done
);

  localparam logic [CNT_W-1:0] WR_TAP  = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] END_TAP = CNT_W'(DONE_AT - 2);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == END_TAP) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign fire_wr = busy && (cnt == WR_TAP);

endmodule

// File: rtl/ddr_wap_colmap.sv
module ddr_wap_colmap
  import ddr_wap_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [COL_W-1:0]  col,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] wr_addr
);

  always_comb begin
    wr_addr     = '0;
    wr_addr[10] = 1'b1;
    case (mode)
      MODE_X4: begin
        wr_addr[9:0] = col[9:0];
        wr_addr[11]  = col[10];
      end
      MODE_X8: wr_addr[9:0] = col[9:0];
      default: wr_addr[8:0] = col[8:0];
    endcase
  end

endmodule

// File: rtl/ddr_wap_cmdout.sv
module ddr_wap_cmdout
  import ddr_wap_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_act,
  input  logic              issue_wr,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [ADDR_W-1:0] act_row,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  output cmd_e              cmd_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else if (issue_act) begin
      cmd_q  <= CMD_ACT;
      ba_q   <= act_bank;
      addr_q <= act_row;
    end else if (issue_wr) begin
      cmd_q  <= CMD_WR;
      ba_q   <= wr_bank;
      addr_q <= wr_addr;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end
  end

endmodule

// File: rtl/ddr_wap_sequencer.sv
module ddr_wap_sequencer
  import ddr_wap_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 6,
  parameter int T_WR   = 2,
  parameter int T_RP   = 3,
  parameter int WL     = 1,
  parameter int BL     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        req_mode,
  output logic              done,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int PRE_AT  = pre_point(T_RCD, WL, BL, T_WR, T_RAS);
  localparam int DONE_AT = PRE_AT + T_RP;
  localparam int CNT_W   = $clog2(DONE_AT + 1);

  logic              busy;
  logic              fire_wr;
  logic              accept;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [1:0]        mode_q;
  logic [ADDR_W-1:0] wr_addr;
  cmd_e              cmd_q;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      col_q  <= '0;
      mode_q <= MODE_X4;
    end else if (accept) begin
      bank_q <= req_bank;
      col_q  <= req_col;
      mode_q <= req_mode;
    end
  end

  ddr_wap_timer #(
    .T_RCD  (T_RCD),
    .DONE_AT(DONE_AT),
    .CNT_W  (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .busy   (busy),
    .fire_wr(fire_wr),
    .done   (done)
  );

  ddr_wap_colmap #(
    .ADDR_W(ADDR_W)
  ) u_colmap (
    .col    (col_q),
    .mode   (mode_q),
    .wr_addr(wr_addr)
  );

  ddr_wap_cmdout #(
    .BANK_W(BANK_W),
    .ADDR_W(ADDR_W)
  ) u_cmdout (
    .clk      (clk),
    .rst      (rst),
    .issue_act(accept),
    .issue_wr (fire_wr),
    .act_bank (req_bank),
    .act_row  (req_row),
    .wr_bank  (bank_q),
    .wr_addr  (wr_addr),
    .cmd_q    (cmd_q),
    .ba_q     (ba),
    .addr_q   (addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

endmodule

// File: rtl/ddr_wap_sequencer_chk.sv
module ddr_wap_sequencer_chk #(
  parameter int BANK_W  = 2,
  parameter int ADDR_W  = 13,
  parameter int T_RCD   = 3,
  parameter int DONE_AT = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ADDR_W-1:0] addr
);

  localparam int SW = $clog2(DONE_AT + 2);
  localparam logic [SW-1:0] SAT = SW'(DONE_AT + 1);

  logic [3:0]    cmd;
  logic          is_act, is_wr, is_nop;
  logic [SW-1:0] since_act;
  logic          seen_act;

  assign cmd    = {cs_n, ras_n, cas_n, we_n};
  assign is_act = (cmd == 4'b0011);
  assign is_wr  = (cmd == 4'b0100);
  assign is_nop = (cmd == 4'b0111);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '0;
      seen_act  <= 1'b0;
    end else if (is_act) begin
      since_act <= SW'(1);
      seen_act  <= 1'b1;
    end else if (since_act < SAT) begin
      since_act <= since_act + 1'b1;
    end
  end

  p_only_legal_cmds_r7: assert property (@(posedge clk) disable iff (rst)
    is_act || is_wr || is_nop);

  p_nop_bus_idle_r7: assert property (@(posedge clk) disable iff (rst)
    is_nop |-> (addr == '0) && (ba == '0));

  p_wr_autopre_r3: assert property (@(posedge clk) disable iff (rst)
    is_wr |-> addr[10]);

  p_wr_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    is_wr |-> seen_act && (since_act == SW'(T_RCD)));

  p_act_from_accept_r2: assert property (@(posedge clk) disable iff (rst)
    is_act |-> $past(req_valid && req_ready && !rst));

  p_act_spacing_r11: assert property (@(posedge clk) disable iff (rst)
    (is_act && seen_act) |-> (since_act >= SW'(DONE_AT)));

  p_accept_drops_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_with_ready_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

endmodule

bind ddr_wap_sequencer ddr_wap_sequencer_chk #(
  .BANK_W (BANK_W),
  .ADDR_W (ADDR_W),
  .T_RCD  (T_RCD),
  .DONE_AT(DONE_AT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .cs_n     (cs_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .ba       (ba),
  .addr     (addr)
);

// File: tb/ddr_wap_sequencer_test.sv
`timescale 1ns/1ps
module ddr_wap_sequencer_test;

  localparam int DONE    = 11;  // R8 at defaults
  localparam int WR_CYC  = 3;   // R3 at defaults
  localparam int DONE_R  = 13;  // R9 with T_RAS = 10

  typedef struct packed {
    logic [1:0]  bank;
    logic [12:0] row;
    logic [10:0] col;
    logic [1:0]  mode;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 13'h1ABC, 11'h7FF, 2'b00},
    '{2'd2, 13'h0123, 11'h5A5, 2'b01},
    '{2'd3, 13'h1FFF, 11'h7FF, 2'b10},
    '{2'd0, 13'h0F0F, 11'h6AA, 2'b11},
    '{2'd2, 13'h0001, 11'h400, 2'b00},
    '{2'd1, 13'h1555, 11'h3FF, 2'b01}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        r_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic [1:0]  req_mode = '0;
  logic        req_ready, done, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        r_ready, r_done, r_cs_n, r_ras_n, r_cas_n, r_we_n;
  logic [1:0]  r_ba;
  logic [12:0] r_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  ddr_wap_sequencer uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_mode(req_mode),
    .done(done), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr)
  );

  ddr_wap_sequencer #(.T_RAS(10)) uut_ras (
    .clk(clk), .rst(rst), .req_valid(r_valid), .req_ready(r_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_mode(req_mode),
    .done(r_done), .cs_n(r_cs_n), .ras_n(r_ras_n), .cas_n(r_cas_n), .we_n(r_we_n),
    .ba(r_ba), .addr(r_addr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  function automatic logic [12:0] exp_wr_addr(input logic [10:0] c, input logic [1:0] m);
    logic [12:0] a;
    a = '0;
    a[10] = 1'b1;
    if (m == 2'b00) begin a[9:0] = c[9:0]; a[11] = c[10]; end
    else if (m == 2'b01) a[9:0] = c[9:0];
    else a[8:0] = c[8:0];
    return a;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    return (m == 2'b00) ? "R4" : (m == 2'b01) ? "R5" : "R6";
  endfunction

  task automatic drive(input vec_t v);
    req_bank = v.bank; req_row = v.row; req_col = v.col; req_mode = v.mode;
    req_valid = 1'b1;
  endtask

  task automatic start_req(input vec_t v);
    @(negedge clk);
    drive(v);
    while (!req_ready) @(negedge clk);
  endtask

  // Accept edge, then watch cycles 0..DONE-1
  task automatic observe(input vec_t v, input bit intrude, input bit chain,
                         input vec_t nv, input string act_tag);
    @(posedge clk);
    for (int k = 0; k < DONE; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        chk(act_tag, {cs_n, ras_n, cas_n, we_n}, 4'b0011);
        chk("R2 act bank", ba, v.bank);
        chk("R2 act row", addr, v.row);
      end else if (k == WR_CYC) begin
        chk("R3 wr cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0100);
        chk("R3 wr bank", ba, v.bank);
        chk(mode_tag(v.mode), addr, exp_wr_addr(v.col, v.mode));
      end else begin
        chk("R7 nop", {cs_n, ras_n, cas_n, we_n, ba, addr}, {4'b0111, 2'b0, 13'b0});
      end
      chk("R8 ready", req_ready, (k == DONE - 1));
      chk("R8 done", done, (k == DONE - 1));
      if (intrude && k == 1) begin
        req_bank = ~v.bank; req_row = ~v.row; req_col = ~v.col; req_mode = v.mode;
        req_valid = 1'b1;  // R10: must be ignored
      end
      if (intrude && k == 6) req_valid = 1'b0;
      if (chain && k == DONE - 1) drive(nv);
    end
  endtask

  initial begin
    vec_t dummy;
    dummy = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R1 bus", {ba, addr}, 15'b0);
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 done", done, 1'b0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      start_req(VECS[i]);
      observe(VECS[i], (i == 1), 1'b0, dummy, "R2 act cmd");
    end

    // R11 back-to-back
    start_req(VECS[0]);
    observe(VECS[0], 1'b0, 1'b1, VECS[2], "R2 act cmd");
    observe(VECS[2], 1'b0, 1'b0, dummy, "R11 back-to-back act");

    // R12 reset mid-sequence
    start_req(VECS[3]);
    @(posedge clk);
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R12 bus", {ba, addr}, 15'b0);
    chk("R12 ready", req_ready, 1'b1);
    chk("R12 done", done, 1'b0);
    start_req(VECS[4]);
    observe(VECS[4], 1'b0, 1'b0, dummy, "R12 restart act");

    // R9 row-active time dominates precharge point
    @(negedge clk);
    req_bank = 2'd3; req_row = 13'h0AAA; req_col = 11'h155; req_mode = 2'b01;
    r_valid = 1'b1;
    @(posedge clk);
    begin
      int seen;
      seen = -1;
      for (int k = 0; k < DONE_R + 4; k++) begin
        @(negedge clk);
        if (k == 0) begin
          r_valid = 1'b0;
          chk("R9 act", {r_cs_n, r_ras_n, r_cas_n, r_we_n}, 4'b0011);
        end
        if (k == WR_CYC) chk("R9 wr", {r_cs_n, r_ras_n, r_cas_n, r_we_n}, 4'b0100);
        if (r_done && seen < 0) seen = k;
        if (k == DONE_R - 2) chk("R9 ready low", r_ready, 1'b0);
      end
      chk("R9 done cycle", seen, DONE_R - 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

endmodule